// File: doc/BRIEF.md
# Vertex Attribute Fetcher

This block gathers the per-vertex inputs of a shading pass. Software first programs a small table of attribute records. Each record gives a base address, a byte stride, a vector size, an element type, an instance divisor, a highest valid index, and two component counts: one for the full vertex pass and one for the position-only coordinate pass. A start pulse then launches one batch of sixteen vertices, beginning at a given first vertex number and using a given instance number. For each vertex, the block walks the active records in table order and reads each component through a 32-bit word read port. It widens the element to 32 bits and writes the result into the vertex pipe memory. That memory has one column per vertex of the batch, and the components of a vertex land in consecutive rows.

The output memory is divided into batch slots that rotate from one batch to the next. The number of slots in use is chosen per batch, between two and four. The block also reports how many eight-row segments one vertex needs under the current table and mode, so a downstream allocator can reserve space. A one-cycle done pulse closes each batch.

Top module: `vattr_fetch`

## Requirements
- R1: A record write (rec_we high at a clock edge) stores all fields into the entry chosen by rec_sel, and the next batch uses the stored values. Entries that were not written keep their earlier contents. A component count above MAX_COMP is stored as MAX_COMP.
- R2: With a divisor of 0, the index of column c is first_vertex + c. The element byte address is base + index*stride + k*size, where k is the component number and size is 4, 1 or 2 bytes by type. mem_addr carries that address with bits [1:0] cleared, and the element is taken from the byte or halfword lane given by the dropped bits.
- R3: With a nonzero divisor d, every column of the batch uses the index instance_id / d, rounded down.
- R4: An index greater than the record's highest valid index is replaced by that highest index.
- R5: Type codes: 0 is a 32-bit float passed through unchanged, 1 is a signed byte, 2 is an unsigned byte, 3 is a signed halfword, 4 is an unsigned halfword. Signed types are sign-extended to 32 bits and unsigned types are zero-extended.
- R6: When cfg_coord is 1, each record contributes its coordinate-pass count of components; otherwise it contributes its vertex-pass count. A record with a count of 0 writes nothing and issues no read.
- R7: A component whose number is at or above the vector size issues no read. Its value is 0, except that component MAX_COMP-1 gets 32'h3F800000 for the float type and 1 for integer types.
- R8: Writes go to column 0 through 15 in order. Within a column, records are visited in table order and components in ascending order. The rows are consecutive, starting at the slot base (slot number × SLOT_ROWS).
- R9: seg_count equals the total components per vertex, taken over the active records under the current cfg_coord, divided by 8 and rounded up. For example, 10 components give 2 segments.
- R10: The slot count is latched at start and limited to the range 2..MAX_SLOTS. The slot advances by one after each batch and wraps to 0 after the last slot. If the slot is beyond the new count at start, it restarts at 0. batch_slot shows the current slot.
- R11: After reset, busy, done, vpm_we and mem_req are low and batch_slot is 0. busy is high from the cycle after start until the batch ends. A start pulse while busy is ignored. done is high for exactly one cycle per batch, with busy low. When the last active record writes rows, done comes in the cycle right after the final vpm_we.
- R12: At most one read is outstanding. After mem_req, no further request is made until mem_valid has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_we | input | 1 | Record write strobe |
| rec_sel | input | AIDX_W | Record entry to write |
| rec_base | input | 32 | Attribute base byte address |
| rec_stride | input | 16 | Byte distance between consecutive indices |
| rec_divisor | input | 16 | Instance divisor, 0 means per-vertex |
| rec_max_idx | input | 16 | Highest valid index |
| rec_type | input | 3 | Element type code |
| rec_vsize | input | 3 | Components present in memory |
| rec_vcount | input | 3 | Components written in vertex pass |
| rec_ccount | input | 3 | Components written in coordinate pass |
| cfg_num_attr | input | ACNT_W | Number of active records (0 treated as 1) |
| cfg_coord | input | 1 | 1 selects coordinate pass counts |
| cfg_slots | input | SCNT_W | Requested number of batch slots |
| start | input | 1 | Begin a batch |
| first_vertex | input | 16 | Vertex number of column 0 |
| instance_id | input | 16 | Instance number of the batch |
| busy | output | 1 | Batch in progress |
| done | output | 1 | One-cycle end-of-batch pulse |
| seg_count | output | SEG_W | Eight-row segments needed per vertex |
| batch_slot | output | SLOT_W | Current output slot |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Word-aligned read byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| vpm_we | output | 1 | Vertex memory write strobe |
| vpm_row | output | ROW_W | Vertex memory row |
| vpm_col | output | COL_W | Vertex memory column (vertex in batch) |
| vpm_data | output | 32 | Converted component |

## Verification
The bench builds the block with its defaults: four records, at most four components each, sixteen-vertex batches, eight-row segments and four slots. This gives a 16-row slot stride and a 64-row memory. With these values, a single vertex can reach the two-segment case (ten components) and a full 16-row slot. The bench also exercises slot wrap at three slots and the clamp of a one-slot request up to two. Reads are answered with varying latency. Every write is compared against a model of memory built from an address hash, which puts sign bits on both sides of every type conversion.

// File: rtl/vfetch_pkg.sv
// Shared types for the vertex attribute fetcher.
// Assumes addresses are 32 bits and index-like fields are 16 bits.
package vfetch_pkg;

    localparam int VF_ADDR_W = 32;
    localparam int VF_IDX_W  = 16;
    localparam int VF_CNT_W  = 3;

    typedef enum logic [2:0] {
        ET_F32 = 3'd0,
        ET_S8  = 3'd1,
        ET_U8  = 3'd2,
        ET_S16 = 3'd3,
        ET_U16 = 3'd4
    } elem_t;

    typedef struct packed {
        logic [VF_ADDR_W-1:0] base;
        logic [VF_IDX_W-1:0]  stride;
        logic [VF_IDX_W-1:0]  divisor;
        logic [VF_IDX_W-1:0]  max_idx;
        elem_t                etype;
        logic [VF_CNT_W-1:0]  vsize;
        logic [VF_CNT_W-1:0]  vcnt;
        logic [VF_CNT_W-1:0]  ccnt;
    } attr_rec_t;

    // Byte size of one element of the given type.
    function automatic logic [2:0] elem_bytes(elem_t t);
        case (t)
            ET_F32:        return 3'd4;
            ET_S8, ET_U8:  return 3'd1;
            default:       return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/vf_rec_store.sv
// Attribute record table plus per-vertex segment sizing.
// Assumes num_attr is already limited to 1..NUM_ATTR by the caller.
module vf_rec_store
    import vfetch_pkg::*;
#(
    parameter int NUM_ATTR = 4,
    parameter int MAX_COMP = 4,
    parameter int SEG_ROWS = 8,
    localparam int AIDX_W  = (NUM_ATTR > 1) ? $clog2(NUM_ATTR) : 1,
    localparam int ACNT_W  = $clog2(NUM_ATTR + 1),
    localparam int RPV_W   = $clog2(NUM_ATTR * MAX_COMP + 1),
    localparam int SEG_W   = $clog2((NUM_ATTR * MAX_COMP + SEG_ROWS - 1) / SEG_ROWS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AIDX_W-1:0] wsel,
    input  attr_rec_t         wrec,
    input  logic [AIDX_W-1:0] rsel,
    input  logic              coord,
    input  logic [ACNT_W-1:0] num_attr,
    output attr_rec_t         rrec,
    output logic [SEG_W-1:0]  seg_count
);

    attr_rec_t        recs [NUM_ATTR];
    logic [RPV_W-1:0] rows;

    // Limit a component count to MAX_COMP.
    function automatic logic [VF_CNT_W-1:0] cap(logic [VF_CNT_W-1:0] c);
        return (int'(c) > MAX_COMP) ? VF_CNT_W'(MAX_COMP) : c;
    endfunction

    for (genvar g = 0; g < NUM_ATTR; g++) begin : g_entry
        // Hold one record; load it on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                recs[g] <= '0;
            end else if (we && wsel == AIDX_W'(g)) begin
                recs[g]      <= wrec;
                recs[g].vcnt <= cap(wrec.vcnt);
                recs[g].ccnt <= cap(wrec.ccnt);
            end
        end
    end

    assign rrec = recs[rsel];

    // Sum the components one vertex needs in the selected pass.
    always_comb begin
        rows = '0;
        for (int i = 0; i < NUM_ATTR; i++) begin
            if (ACNT_W'(i) < num_attr)
                rows = rows + RPV_W'(coord ? recs[i].ccnt : recs[i].vcnt);
        end
    end

    assign seg_count = SEG_W'((int'(rows) + SEG_ROWS - 1) / SEG_ROWS);

    // R9: segments cover the rows with less than one spare segment
    p_seg_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(seg_count) * SEG_ROWS >= int'(rows)) &&
        (seg_count == '0 || (int'(seg_count) - 1) * SEG_ROWS < int'(rows)));

endmodule

// File: rtl/vf_addr_gen.sv
// Index selection, clamping and element address for one component.
// Purely combinational; assumes a zero divisor selects the vertex index.
module vf_addr_gen
    import vfetch_pkg::*;
(
    input  attr_rec_t             rec,
    input  logic [VF_IDX_W-1:0]   vidx,
    input  logic [VF_IDX_W-1:0]   inst,
    input  logic [VF_CNT_W-1:0]   comp,
    output logic [VF_IDX_W-1:0]   index,
    output logic [VF_ADDR_W-1:0]  addr
);

    logic [VF_IDX_W-1:0] raw_idx;

    // Pick the vertex or divided instance index, then clamp it.
    always_comb begin
        raw_idx = (rec.divisor == '0) ? vidx : (inst / rec.divisor);
        index   = (raw_idx > rec.max_idx) ? rec.max_idx : raw_idx;
        addr    = rec.base
                + VF_ADDR_W'(index) * VF_ADDR_W'(rec.stride)
                + VF_ADDR_W'(comp) * VF_ADDR_W'(elem_bytes(rec.etype));
    end

endmodule

// File: rtl/vf_convert.sv
// Lane extraction and widening of one element to 32 bits.
// Assumes halfwords are 2-byte aligned so lane[0] is 0 for them.
module vf_convert
    import vfetch_pkg::*;
(
    input  elem_t       etype,
    input  logic [1:0]  lane,
    input  logic [31:0] word,
    output logic [31:0] value
);

    logic [7:0]  byte_v;
    logic [15:0] half_v;

    // Select the addressed lane and extend it by type.
    always_comb begin
        byte_v = 8'(word >> {lane, 3'b000});
        half_v = lane[1] ? word[31:16] : word[15:0];
        case (etype)
            ET_S8:   value = {{24{byte_v[7]}}, byte_v};
            ET_U8:   value = {24'd0, byte_v};
            ET_S16:  value = {{16{half_v[15]}}, half_v};
            ET_U16:  value = {16'd0, half_v};
            default: value = word;
        endcase
    end

endmodule

// File: rtl/vattr_fetch.sv
// Vertex attribute fetcher: walks 16-vertex batches, reads each component
// through a single-outstanding word port and writes the widened values into
// vertex pipe memory, one column per vertex, slots rotating per batch.
// Assumes mem_valid answers each mem_req exactly once, any cycle later.
module vattr_fetch
    import vfetch_pkg::*;
#(
    parameter int NUM_ATTR  = 4,
    parameter int MAX_COMP  = 4,
    parameter int BATCH     = 16,
    parameter int SEG_ROWS  = 8,
    parameter int MAX_SLOTS = 4,
    localparam int AIDX_W    = (NUM_ATTR > 1) ? $clog2(NUM_ATTR) : 1,
    localparam int ACNT_W    = $clog2(NUM_ATTR + 1),
    localparam int COL_W     = $clog2(BATCH),
    localparam int MAX_ROWS  = NUM_ATTR * MAX_COMP,
    localparam int MAX_SEGS  = (MAX_ROWS + SEG_ROWS - 1) / SEG_ROWS,
    localparam int SEG_W     = $clog2(MAX_SEGS + 1),
    localparam int SLOT_ROWS = MAX_SEGS * SEG_ROWS,
    localparam int SLOT_W    = $clog2(MAX_SLOTS),
    localparam int SCNT_W    = $clog2(MAX_SLOTS + 1),
    localparam int ROW_W     = $clog2(SLOT_ROWS * MAX_SLOTS),
    localparam int RCNT_W    = $clog2(SLOT_ROWS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rec_we,
    input  logic [AIDX_W-1:0]    rec_sel,
    input  logic [31:0]          rec_base,
    input  logic [15:0]          rec_stride,
    input  logic [15:0]          rec_divisor,
    input  logic [15:0]          rec_max_idx,
    input  logic [2:0]           rec_type,
    input  logic [2:0]           rec_vsize,
    input  logic [2:0]           rec_vcount,
    input  logic [2:0]           rec_ccount,
    input  logic [ACNT_W-1:0]    cfg_num_attr,
    input  logic                 cfg_coord,
    input  logic [SCNT_W-1:0]    cfg_slots,
    input  logic                 start,
    input  logic [15:0]          first_vertex,
    input  logic [15:0]          instance_id,
    output logic                 busy,
    output logic                 done,
    output logic [SEG_W-1:0]     seg_count,
    output logic [SLOT_W-1:0]    batch_slot,
    output logic                 mem_req,
    output logic [31:0]          mem_addr,
    input  logic                 mem_valid,
    input  logic [31:0]          mem_rdata,
    output logic                 vpm_we,
    output logic [ROW_W-1:0]     vpm_row,
    output logic [COL_W-1:0]     vpm_col,
    output logic [31:0]          vpm_data
);

    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_FIN} st_t;

    st_t                 st_q;
    logic [COL_W-1:0]    col_q;
    logic [AIDX_W-1:0]   attr_q;
    logic [VF_CNT_W-1:0] comp_q;
    logic [RCNT_W-1:0]   row_q;
    logic [SLOT_W-1:0]   slot_q;
    logic [SCNT_W-1:0]   slots_q;
    logic [ACNT_W-1:0]   nattr_q;
    logic [ACNT_W-1:0]   nattr_live;
    logic [SCNT_W-1:0]   slots_live;
    logic [15:0]         fv_q;
    logic [15:0]         inst_q;
    logic                coord_q;

    attr_rec_t           wr_rec;
    attr_rec_t           cur;
    logic [15:0]         ag_index;
    logic [31:0]         ag_addr;
    logic [31:0]         conv_val;
    logic [31:0]         fill_val;
    logic [VF_CNT_W-1:0] cnt;
    logic                in_req, skip_attr, fill_now, got, write_now, step;
    logic                last_comp, last_attr, last_col;
    logic                outst_q;

    // Limit the requested record and slot counts to legal ranges.
    always_comb begin
        nattr_live = (cfg_num_attr == '0) ? ACNT_W'(1)
                   : (int'(cfg_num_attr) > NUM_ATTR) ? ACNT_W'(NUM_ATTR) : cfg_num_attr;
        slots_live = (int'(cfg_slots) < 2) ? SCNT_W'(2)
                   : (int'(cfg_slots) > MAX_SLOTS) ? SCNT_W'(MAX_SLOTS) : cfg_slots;
    end

    // Pack the record write fields.
    always_comb begin
        wr_rec.base    = rec_base;
        wr_rec.stride  = rec_stride;
        wr_rec.divisor = rec_divisor;
        wr_rec.max_idx = rec_max_idx;
        wr_rec.etype   = elem_t'(rec_type);
        wr_rec.vsize   = rec_vsize;
        wr_rec.vcnt    = rec_vcount;
        wr_rec.ccnt    = rec_ccount;
    end

    vf_rec_store #(.NUM_ATTR(NUM_ATTR), .MAX_COMP(MAX_COMP), .SEG_ROWS(SEG_ROWS)) u_store (
        .clk(clk), .rst_n(rst_n), .we(rec_we), .wsel(rec_sel), .wrec(wr_rec),
        .rsel(attr_q), .coord(cfg_coord), .num_attr(nattr_live),
        .rrec(cur), .seg_count(seg_count)
    );

    vf_addr_gen u_addr (
        .rec(cur), .vidx(fv_q + 16'(col_q)), .inst(inst_q), .comp(comp_q),
        .index(ag_index), .addr(ag_addr)
    );

    vf_convert u_conv (
        .etype(cur.etype), .lane(ag_addr[1:0]), .word(mem_rdata), .value(conv_val)
    );

    // Decode what the current step does.
    always_comb begin
        cnt       = coord_q ? cur.ccnt : cur.vcnt;
        in_req    = (st_q == S_REQ);
        skip_attr = in_req && (cnt == '0);
        fill_now  = in_req && (cnt != '0) && !(comp_q < cur.vsize);
        mem_req   = in_req && (cnt != '0) && (comp_q < cur.vsize);
        got       = (st_q == S_WAIT) && mem_valid;
        write_now = fill_now || got;
        step      = skip_attr || write_now;
        last_comp = (cnt == '0) || (comp_q == cnt - VF_CNT_W'(1));
        last_attr = (ACNT_W'(attr_q) == nattr_q - ACNT_W'(1));
        last_col  = (col_q == COL_W'(BATCH - 1));
        if (comp_q == VF_CNT_W'(MAX_COMP - 1))
            fill_val = (cur.etype == ET_F32) ? 32'h3F80_0000 : 32'd1;
        else
            fill_val = 32'd0;
    end

    assign mem_addr   = {ag_addr[31:2], 2'b00};
    assign busy       = (st_q != S_IDLE);
    assign batch_slot = slot_q;

    // Batch sequencer, counters and registered memory write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= S_IDLE;
            col_q    <= '0;
            attr_q   <= '0;
            comp_q   <= '0;
            row_q    <= '0;
            slot_q   <= '0;
            slots_q  <= SCNT_W'(2);
            nattr_q  <= ACNT_W'(1);
            fv_q     <= '0;
            inst_q   <= '0;
            coord_q  <= 1'b0;
            done     <= 1'b0;
            vpm_we   <= 1'b0;
            vpm_row  <= '0;
            vpm_col  <= '0;
            vpm_data <= '0;
        end else begin
            vpm_we <= 1'b0;
            done   <= 1'b0;
            case (st_q)
                S_IDLE: if (start) begin
                    fv_q    <= first_vertex;
                    inst_q  <= instance_id;
                    coord_q <= cfg_coord;
                    nattr_q <= nattr_live;
                    slots_q <= slots_live;
                    if (SCNT_W'(slot_q) >= slots_live) slot_q <= '0;
                    col_q   <= '0;
                    attr_q  <= '0;
                    comp_q  <= '0;
                    row_q   <= '0;
                    st_q    <= S_REQ;
                end
                S_REQ:  if (mem_req) st_q <= S_WAIT;
                S_FIN: begin
                    done   <= 1'b1;
                    slot_q <= (SCNT_W'(slot_q) + SCNT_W'(1) >= slots_q) ? '0 : slot_q + SLOT_W'(1);
                    st_q   <= S_IDLE;
                end
                default: ;
            endcase
            if (write_now) begin
                vpm_we   <= 1'b1;
                vpm_row  <= ROW_W'(slot_q) * ROW_W'(SLOT_ROWS) + ROW_W'(row_q);
                vpm_col  <= col_q;
                vpm_data <= got ? conv_val : fill_val;
                row_q    <= row_q + RCNT_W'(1);
            end
            if (step) begin
                st_q <= S_REQ;
                if (last_comp) begin
                    comp_q <= '0;
                    if (last_attr) begin
                        attr_q <= '0;
                        row_q  <= '0;
                        if (last_col) st_q <= S_FIN;
                        else          col_q <= col_q + COL_W'(1);
                    end else begin
                        attr_q <= attr_q + AIDX_W'(1);
                    end
                end else begin
                    comp_q <= comp_q + VF_CNT_W'(1);
                end
            end
        end
    end

    // Track an outstanding read for the single-request check.
    always_ff @(posedge clk) begin
        if (!rst_n)         outst_q <= 1'b0;
        else if (mem_req)   outst_q <= 1'b1;
        else if (mem_valid) outst_q <= 1'b0;
    end

    // R12: no new request while a read is pending
    p_one_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !outst_q);

    // R11: done is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: done arrives with the block idle
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: a requested index never exceeds the record limit
    p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (ag_index <= cur.max_idx));

    // R10: the current slot stays inside the latched slot count
    p_slot_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (SCNT_W'(batch_slot) < slots_q));

endmodule

// File: tb/vattr_fetch_test.sv
// Directed bench for the vertex attribute fetcher.
module vattr_fetch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_we = 1'b0;
    logic [1:0]  rec_sel = '0;
    logic [31:0] rec_base = '0;
    logic [15:0] rec_stride = '0, rec_divisor = '0, rec_max_idx = '0;
    logic [2:0]  rec_type = '0, rec_vsize = '0, rec_vcount = '0, rec_ccount = '0;
    logic [2:0]  cfg_num_attr = 3'd1;
    logic        cfg_coord = 1'b0;
    logic [2:0]  cfg_slots = 3'd4;
    logic        start = 1'b0;
    logic [15:0] first_vertex = '0, instance_id = '0;
    logic        busy, done, mem_req, vpm_we;
    logic [1:0]  seg_count, batch_slot;
    logic [31:0] mem_addr, vpm_data;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [5:0]  vpm_row;
    logic [3:0]  vpm_col;

    vattr_fetch uut (
        .clk(clk), .rst_n(rst_n), .rec_we(rec_we), .rec_sel(rec_sel),
        .rec_base(rec_base), .rec_stride(rec_stride), .rec_divisor(rec_divisor),
        .rec_max_idx(rec_max_idx), .rec_type(rec_type), .rec_vsize(rec_vsize),
        .rec_vcount(rec_vcount), .rec_ccount(rec_ccount), .cfg_num_attr(cfg_num_attr),
        .cfg_coord(cfg_coord), .cfg_slots(cfg_slots), .start(start),
        .first_vertex(first_vertex), .instance_id(instance_id), .busy(busy), .done(done),
        .seg_count(seg_count), .batch_slot(batch_slot), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .vpm_we(vpm_we), .vpm_row(vpm_row), .vpm_col(vpm_col), .vpm_data(vpm_data)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    int s_base[4], s_stride[4], s_div[4], s_max[4], s_type[4], s_vs[4], s_vc[4], s_cc[4];
    int cap_row[256], cap_col[256];
    logic [31:0] cap_data[256];
    int e_row[256], e_col[256];
    logic [31:0] e_data[256];
    int ncap = 0, ne = 0, ndone = 0, overlap = 0, eslot = 0, lat = 1, e_rows = 0;
    bit prev_we = 0, done_after_we = 0;
    bit pend = 0;
    int pcnt = 0;
    logic [31:0] paddr = '0;

    // Memory contents: a hash of the word address.
    function automatic logic [31:0] memword(input logic [31:0] a);
        return (a ^ 32'h5A5A_0000) * 32'h0001_0DCD + 32'h3C6E_F35F;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Memory responder with programmable latency; flags overlapping requests.
    always @(negedge clk) begin
        if (pend && pcnt == 1) begin
            mem_valid = 1'b1;
            mem_rdata = memword(paddr);
            pend = 0;
        end else begin
            mem_valid = 1'b0;
            if (pend) pcnt--;
        end
        if (mem_req) begin
            if (pend) overlap++;
            pend = 1;
            paddr = mem_addr;
            pcnt = lat;
        end
    end

    // Capture writes and done timing.
    always @(negedge clk) begin
        if (vpm_we && ncap < 256) begin
            cap_row[ncap] = int'(vpm_row);
            cap_col[ncap] = int'(vpm_col);
            cap_data[ncap] = vpm_data;
            ncap++;
        end
        if (done) begin
            ndone++;
            done_after_we = prev_we;
        end
        prev_we = vpm_we;
    end

    task automatic wr_rec(input int i, input int base, input int stride, input int dv,
                          input int mx, input int ty, input int vs, input int vc, input int cc);
        @(negedge clk);
        rec_sel = 2'(i); rec_base = 32'(base); rec_stride = 16'(stride);
        rec_divisor = 16'(dv); rec_max_idx = 16'(mx); rec_type = 3'(ty);
        rec_vsize = 3'(vs); rec_vcount = 3'(vc); rec_ccount = 3'(cc);
        rec_we = 1'b1;
        @(negedge clk);
        rec_we = 1'b0;
        s_base[i] = base; s_stride[i] = stride; s_div[i] = dv; s_max[i] = mx;
        s_type[i] = ty; s_vs[i] = vs; s_vc[i] = (vc > 4) ? 4 : vc; s_cc[i] = (cc > 4) ? 4 : cc;
    endtask

    // Expected value of one component, from the requirements.
    function automatic logic [31:0] exp_val(input int a, input int col, input int c,
                                            input int fv, input int inst);
        int idx, esz;
        logic [31:0] addr, w;
        logic [7:0] b;
        logic [15:0] h;
        if (c >= s_vs[a]) begin
            if (c == 3) return (s_type[a] == 0) ? 32'h3F80_0000 : 32'd1;
            return 32'd0;
        end
        idx = (s_div[a] == 0) ? ((fv + col) & 16'hFFFF) : (inst / s_div[a]);
        if (idx > s_max[a]) idx = s_max[a];
        esz = (s_type[a] == 0) ? 4 : ((s_type[a] <= 2) ? 1 : 2);
        addr = 32'(s_base[a] + idx * s_stride[a] + c * esz);
        w = memword({addr[31:2], 2'b00});
        b = 8'(w >> (8 * addr[1:0]));
        h = addr[1] ? w[31:16] : w[15:0];
        case (s_type[a])
            1: return {{24{b[7]}}, b};
            2: return {24'd0, b};
            3: return {{16{h[15]}}, h};
            4: return {16'd0, h};
            default: return w;
        endcase
    endfunction

    task automatic build_exp(input int fv, input int inst, input int coord,
                             input int nattr, input int rowbase);
        ne = 0;
        e_rows = 0;
        for (int a = 0; a < nattr; a++) e_rows += coord ? s_cc[a] : s_vc[a];
        for (int col = 0; col < 16; col++) begin
            int r = 0;
            for (int a = 0; a < nattr; a++) begin
                int n = coord ? s_cc[a] : s_vc[a];
                for (int c = 0; c < n; c++) begin
                    e_row[ne] = rowbase + r;
                    e_col[ne] = col;
                    e_data[ne] = exp_val(a, col, c, fv, inst);
                    ne++;
                    r++;
                end
            end
        end
    endtask

    // Run one batch and compare every write against the model.
    task automatic run_batch(input int fv, input int inst, input int coord, input int nattr,
                             input int slots, input bit poke, input bit last_writes,
                             input string reqs);
        int s;
        @(negedge clk);
        cfg_num_attr = 3'(nattr); cfg_coord = coord[0]; cfg_slots = 3'(slots);
        first_vertex = 16'(fv); instance_id = 16'(inst);
        s = (slots < 2) ? 2 : ((slots > 4) ? 4 : slots);
        if (eslot >= s) eslot = 0;
        build_exp(fv, inst, coord, nattr, eslot * 16);
        #1;
        chk(int'(seg_count) == (e_rows + 7) / 8, "R9", "seg_count", 32'(seg_count), 32'((e_rows + 7) / 8));
        @(negedge clk);
        ncap = 0; ndone = 0; overlap = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11", "busy after start", 32'(busy), 32'd1);
        if (poke) begin
            repeat (20) @(negedge clk);
            chk(busy == 1'b1, "R11", "busy mid batch", 32'(busy), 32'd1);
            first_vertex = 16'(fv + 37);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (ndone == 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(ncap == ne, reqs, "write count", 32'(ncap), 32'(ne));
        for (int i = 0; i < ne && i < ncap; i++) begin
            chk(cap_row[i] == e_row[i] && cap_col[i] == e_col[i] && cap_data[i] == e_data[i],
                reqs, $sformatf("write %0d row %0d col %0d", i, cap_row[i], cap_col[i]),
                cap_data[i], e_data[i]);
        end
        chk(ndone == 1, "R11", "done pulses", 32'(ndone), 32'd1);
        if (last_writes)
            chk(done_after_we, "R11", "done right after last write", 32'(done_after_we), 32'd1);
        chk(overlap == 0, "R12", "overlapping reads", 32'(overlap), 32'd0);
        chk(busy == 1'b0, "R11", "idle after done", 32'(busy), 32'd0);
        eslot = (eslot + 1 >= s) ? 0 : eslot + 1;
        chk(int'(batch_slot) == eslot, "R10", "next slot", 32'(batch_slot), 32'(eslot));
    endtask

    task automatic t_reset();
        chk(busy == 0 && done == 0, "R11", "busy/done at reset", {30'd0, busy, done}, 32'd0);
        chk(vpm_we == 0 && mem_req == 0, "R11", "strobes at reset", {30'd0, vpm_we, mem_req}, 32'd0);
        chk(batch_slot == 0, "R11", "slot at reset", 32'(batch_slot), 32'd0);
    endtask

    task automatic t_basic();  // R1 R2 R5 R8 R9
        lat = 1;
        wr_rec(0, 32'h1000, 12, 0, 1000, 0, 3, 3, 1);
        wr_rec(1, 32'h2000, 4, 0, 1000, 2, 4, 4, 0);
        run_batch(5, 0, 0, 2, 4, 0, 1, "R1 R2 R5 R8");
    endtask

    task automatic t_types();  // R5
        lat = 2;
        wr_rec(0, 32'h3001, 4, 0, 500, 1, 2, 2, 2);
        wr_rec(1, 32'h4002, 8, 0, 500, 3, 2, 2, 2);
        wr_rec(2, 32'h5000, 4, 0, 500, 4, 1, 1, 1);
        wr_rec(3, 32'h6003, 4, 0, 500, 2, 1, 1, 1);
        run_batch(100, 0, 0, 4, 4, 0, 1, "R5 R2");
    endtask

    task automatic t_div_clamp();  // R3 R4
        lat = 3;
        wr_rec(0, 32'h7000, 16, 3, 100, 0, 2, 2, 2);
        wr_rec(1, 32'h8000, 4, 0, 7, 4, 1, 1, 1);
        run_batch(0, 10, 0, 2, 4, 0, 1, "R3 R4");
    endtask

    task automatic t_coord();  // R6
        lat = 1;
        wr_rec(0, 32'h1000, 12, 0, 1000, 0, 3, 3, 1);
        wr_rec(1, 32'h2000, 4, 0, 1000, 2, 4, 4, 0);
        run_batch(40, 0, 1, 2, 4, 0, 0, "R6");
    endtask

    task automatic t_fill();  // R7
        lat = 2;
        wr_rec(0, 32'h9000, 8, 0, 1000, 0, 2, 4, 4);
        wr_rec(1, 32'hA000, 4, 0, 1000, 3, 1, 4, 4);
        run_batch(3, 0, 0, 2, 4, 0, 1, "R7");
    endtask

    task automatic t_ten();  // R9 R1
        lat = 1;
        wr_rec(0, 32'hB000, 16, 0, 1000, 0, 4, 4, 4);
        wr_rec(1, 32'hC000, 4, 0, 1000, 2, 4, 4, 4);
        wr_rec(2, 32'hD000, 8, 0, 1000, 0, 2, 2, 2);
        run_batch(7, 0, 0, 3, 4, 0, 1, "R9 R8");
        wr_rec(1, 32'hE002, 4, 0, 1000, 3, 1, 1, 1);
        run_batch(7, 0, 0, 3, 4, 0, 1, "R1");
    endtask

    task automatic t_slots();  // R10
        lat = 1;
        wr_rec(0, 32'hF000, 4, 0, 1000, 0, 1, 1, 1);
        for (int k = 0; k < 4; k++) run_batch(k * 16, 0, 0, 1, 3, 0, 1, "R10");
        for (int k = 0; k < 3; k++) run_batch(k, 0, 0, 1, 1, 0, 1, "R10");
    endtask

    task automatic t_busy_start();  // R11
        lat = 2;
        wr_rec(0, 32'h1000, 12, 0, 1000, 0, 3, 3, 3);
        run_batch(9, 0, 0, 1, 4, 1, 1, "R11");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_types();
        t_div_clamp();
        t_coord();
        t_fill();
        t_ten();
        t_slots();
        t_busy_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule